// File: doc/BRIEF.md
# Modem Control and Status Register Pair

This block holds two registers of a serial port controller. The control register drives the modem handshake outputs. The status register reports the state of four incoming modem lines, which are carrier detect, ring, data-set-ready and clear-to-send. The block passes each incoming line through a synchronizer and compares it with the last value it recorded. Any difference sets a sticky change flag. The ring line is the exception: its flag is set only when the line goes from active to inactive. The change flags stay set until software reads the status register. While any change flag is set, an event output is raised for the interrupt logic.

A loop-back test mode folds the control outputs back onto the status view. In this mode the external outputs are held inactive and changes on the external lines are ignored. Software reaches both registers through a one-bit address with separate read and write strobes. Read data is combinational in the cycle of the read strobe. Any side effect of a read takes hold at the next clock edge.

Top module: `modem_ctl_status`

## Requirements
- R1: After reset, with the lines held at carrier=1, ring=0, dsr=1, cts=1, the status register (address 1) reads 0xB0, the control register (address 0) reads 0x08, out2Out is 1, rtsOut, dtrOut and out1Out are 0, and msEvent is 0.
- R2: A write to address 0 stores only bits 4:0: loop=bit 4, out2=bit 3, out1=bit 2, rts=bit 1, dtr=bit 0. A read of address 0 returns the stored bits with bits 7:5 zero.
- R3: While loop is clear, dtrOut, rtsOut, out1Out and out2Out equal control bits 0, 1, 2 and 3.
- R4: While loop is clear, status bits 7, 6, 5 and 4 report carrier, ring, dsr and cts. A change on an input pin appears in the status register at the third rising edge after it.
- R5: A change in either direction on cts, dsr or carrier sets status bit 0, 1 or 3 respectively. The bit stays set until a status read.
- R6: Status bit 2 is set only when ring goes from 1 to 0. A rising ring line leaves it unchanged.
- R7: A status read with loop clear returns the current value. From the next cycle it clears bits 3:0 and leaves bits 7:4 unchanged.
- R8: A line change recorded in the same cycle as a clearing status read sets its change bit, so the change is not lost.
- R9: msEvent is 1 exactly when any of status bits 3:0 is set.
- R10: With loop set, a status read returns out2 on bit 7, out1 on bit 6, dtr on bit 5, rts on bit 4 and zeros on bits 3:0. All four modem outputs are 0.
- R11: With loop set, changes on the input pins do not alter the recorded lines or change bits, and a status read clears nothing. When loop is cleared, lines that differ from the recorded values are then detected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 1 | 0 selects control, 1 selects status |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid while rdEn is high |
| ctsIn | input | 1 | Clear-to-send line |
| dsrIn | input | 1 | Data-set-ready line |
| dcdIn | input | 1 | Carrier detect line |
| riIn | input | 1 | Ring line |
| rtsOut | output | 1 | Request-to-send output |
| dtrOut | output | 1 | Data-terminal-ready output |
| out1Out | output | 1 | General output 1 |
| out2Out | output | 1 | General output 2 |
| msEvent | output | 1 | Any change flag pending |

## Verification
The bench raises and lowers the ring line separately. A design that sets the ring change flag on any edge would show bit 2 after the rising edge. The bench also makes a new line change land in the same cycle as a clearing read. A design that gives the clear priority would drop that change and leave msEvent low. In loop-back mode, the bench checks that each control bit lands on its proper status position. It also toggles external lines while in that mode and then leaves it. A design that keeps tracking the pins would raise events during loop-back, or miss the difference when loop-back is left.

// File: rtl/modem_pkg.sv
package modem_pkg;
  localparam int CTRL_W = 5;
  localparam int LINE_W = 4;
  localparam int REG_W  = 8;
  // line vector order: [3] carrier, [2] ring, [1] dsr, [0] cts
  localparam int RING_IDX = 2;
  localparam logic [LINE_W-1:0] LINE_IDLE = 4'b1011;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 5'b01000;
  localparam int LOOP_IDX = 4;

  typedef struct packed {
    logic wrCtrl;
    logic rdCtrl;
    logic rdStatus;
  } modem_stb_t;
endpackage

// File: rtl/modem_ctrl.sv
module modem_ctrl
  import modem_pkg::*;
(
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic             addr,
  input  logic [REG_W-1:0] ctrlView,
  input  logic [REG_W-1:0] statusView,
  output modem_stb_t       stb,
  output logic [REG_W-1:0] rdData
);
  always_comb begin
    stb.wrCtrl   = wrEn & ~addr;
    stb.rdCtrl   = rdEn & ~addr;
    stb.rdStatus = rdEn & addr;
  end

  always_comb begin
    if (stb.rdStatus)    rdData = statusView;
    else if (stb.rdCtrl) rdData = ctrlView;
    else                 rdData = '0;
  end
endmodule

// File: rtl/modem_dp.sv
module modem_dp
  import modem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  modem_stb_t        stb,
  input  logic [CTRL_W-1:0] wrBits,
  input  logic [LINE_W-1:0] lineIn,
  output logic [REG_W-1:0]  ctrlView,
  output logic [REG_W-1:0]  statusView,
  output logic [3:0]        pinsOut,
  output logic              msEvent
);
  logic [CTRL_W-1:0] ctrlReg;
  logic [LINE_W-1:0] syncQ [SYNC_STAGES];
  logic [LINE_W-1:0] lineNew, lineReg, delta, rawDelta;
  logic loop;

  assign loop = ctrlReg[LOOP_IDX];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrlReg <= CTRL_RESET;
    else if (stb.wrCtrl) ctrlReg <= wrBits;
  end

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syncQ[g] <= LINE_IDLE;
        else if (g == 0) syncQ[g] <= lineIn;
        else syncQ[g] <= syncQ[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign lineNew = syncQ[SYNC_STAGES-1];

  always_comb begin
    rawDelta = lineReg ^ lineNew;
    rawDelta[RING_IDX] = lineReg[RING_IDX] & ~lineNew[RING_IDX];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lineReg <= LINE_IDLE;
      delta   <= '0;
    end else if (!loop) begin
      lineReg <= lineNew;
      delta   <= (stb.rdStatus ? '0 : delta) | rawDelta;
    end
  end

  assign ctrlView   = {{(REG_W-CTRL_W){1'b0}}, ctrlReg};
  assign statusView = loop ? {ctrlReg[3], ctrlReg[2], ctrlReg[0], ctrlReg[1], 4'b0000}
                           : {lineReg, delta};
  assign pinsOut    = loop ? 4'b0000 : ctrlReg[3:0];
  assign msEvent    = |delta;

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.rdStatus && !loop && lineNew == lineReg) |=> (delta == '0));

  assert_delta_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb.rdStatus) |=> ((delta & $past(delta)) == $past(delta)));

  assert_ring_fall_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb.rdStatus && !lineReg[RING_IDX]) |=> (delta[RING_IDX] == $past(delta[RING_IDX])));

  assert_loop_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    loop |=> ($stable(lineReg) && $stable(delta)));
endmodule

// File: rtl/modem_ctl_status.sv
module modem_ctl_status
  import modem_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic       addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       ctsIn,
  input  logic       dsrIn,
  input  logic       dcdIn,
  input  logic       riIn,
  output logic       rtsOut,
  output logic       dtrOut,
  output logic       out1Out,
  output logic       out2Out,
  output logic       msEvent
);
  modem_stb_t stb;
  logic [REG_W-1:0] ctrlView, statusView;
  logic [3:0] pinsOut;

  modem_ctrl uCtrl (
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .ctrlView(ctrlView), .statusView(statusView),
    .stb(stb), .rdData(rdData)
  );

  modem_dp #(.SYNC_STAGES(2)) uDp (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .wrBits(wrData[CTRL_W-1:0]),
    .lineIn({dcdIn, riIn, dsrIn, ctsIn}),
    .ctrlView(ctrlView), .statusView(statusView),
    .pinsOut(pinsOut), .msEvent(msEvent)
  );

  assign dtrOut  = pinsOut[0];
  assign rtsOut  = pinsOut[1];
  assign out1Out = pinsOut[2];
  assign out2Out = pinsOut[3];
endmodule

// File: tb/modem_ctl_status_test.sv
module modem_ctl_status_test;
  logic clk = 0, rst_n = 0;
  logic wrEn = 0, rdEn = 0, addr = 0;
  logic [7:0] wrData = 0;
  logic [7:0] rdData;
  logic ctsIn = 1, dsrIn = 1, dcdIn = 1, riIn = 0;
  logic rtsOut, dtrOut, out1Out, out2Out, msEvent;
  int nTests = 0, nFail = 0;

  modem_ctl_status uut (.*);

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic writeCtrl(input logic [7:0] v);
    wrEn = 1; addr = 0; wrData = v;
    @(posedge clk); @(negedge clk);
    wrEn = 0;
  endtask

  task automatic readReg(input logic a, output logic [7:0] v);
    rdEn = 1; addr = a;
    #1 v = rdData;
    @(posedge clk); @(negedge clk);
    rdEn = 0;
  endtask

  task automatic setLines(input logic dcd, input logic ri, input logic dsr, input logic cts);
    dcdIn = dcd; riIn = ri; dsrIn = dsr; ctsIn = cts;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] pins();
    return {4'b0, out2Out, out1Out, rtsOut, dtrOut};
  endfunction

  task automatic testReset();
    logic [7:0] v;
    chk("R1 pins", pins(), 8'h08);
    chk("R1 msEvent", {7'b0, msEvent}, 8'h00);
    readReg(0, v); chk("R1 ctrl", v, 8'h08);
    readReg(1, v); chk("R1 status", v, 8'hB0);
  endtask

  task automatic testCtrl();
    logic [7:0] v;
    writeCtrl(8'hEF);
    readReg(0, v); chk("R2 upper bits dropped", v, 8'h0F);
    chk("R3 all outputs", pins(), 8'h0F);
    writeCtrl(8'h05);
    chk("R3 dtr+out1", pins(), 8'h05);
    writeCtrl(8'h08);
  endtask

  task automatic testTrack();
    logic [7:0] v;
    setLines(1, 0, 1, 0);
    chk("R9 event raised", {7'b0, msEvent}, 8'h01);
    readReg(1, v); chk("R4 R5 cts fall", v, 8'hA1);
    readReg(1, v); chk("R7 cleared", v, 8'hA0);
    chk("R9 event low", {7'b0, msEvent}, 8'h00);
    setLines(1, 0, 1, 1);
    readReg(1, v); chk("R5 cts rise", v, 8'hB1);
    readReg(1, v); chk("R7 cleared again", v, 8'hB0);
  endtask

  task automatic testRing();
    logic [7:0] v;
    setLines(1, 1, 1, 1);
    chk("R6 rise no event", {7'b0, msEvent}, 8'h00);
    readReg(1, v); chk("R6 rise", v, 8'hF0);
    setLines(1, 0, 1, 1);
    readReg(1, v); chk("R6 fall", v, 8'hB4);
    readReg(1, v); chk("R7 ring cleared", v, 8'hB0);
  endtask

  task automatic testSimul();
    logic [7:0] v;
    setLines(1, 0, 0, 1);
    ctsIn = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    readReg(1, v); chk("R8 read before change", v, 8'h92);
    chk("R8 event kept", {7'b0, msEvent}, 8'h01);
    readReg(1, v); chk("R8 new delta kept", v, 8'h81);
    setLines(1, 0, 1, 1);
    readReg(1, v); chk("R5 both rise", v, 8'hB3);
    readReg(1, v); chk("R7 clear", v, 8'hB0);
  endtask

  task automatic testLoop();
    logic [7:0] v;
    setLines(1, 0, 1, 0);
    writeCtrl(8'h1A);
    chk("R10 outputs quiet", pins(), 8'h00);
    readReg(1, v); chk("R10 out2 rts map", v, 8'h90);
    chk("R11 read no clear", {7'b0, msEvent}, 8'h01);
    writeCtrl(8'h15);
    readReg(1, v); chk("R10 out1 dtr map", v, 8'h60);
    setLines(0, 0, 1, 1);
    readReg(1, v); chk("R11 pins ignored", v, 8'h60);
    chk("R11 event unchanged", {7'b0, msEvent}, 8'h01);
    setLines(1, 0, 1, 1);
    writeCtrl(8'h08);
    @(posedge clk); @(negedge clk);
    chk("R3 outputs back", pins(), 8'h08);
    readReg(1, v); chk("R11 exit detects", v, 8'hB1);
    readReg(1, v); chk("R7 final clear", v, 8'hB0);
    chk("R9 event low", {7'b0, msEvent}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    testReset();
    testCtrl();
    testTrack();
    testRing();
    testSimul();
    testLoop();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #100000;
    nTests++; nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule